// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit accumulator processor. It holds the accumulator and four status flags: overflow (V), carry (C), zero (Z) and negative (N). Each cycle in which the execute strobe is high, it applies one operation to the accumulator and to a fixed subset of the flags. The operation comes either from a 3-bit memory-operand opcode, which works on an operand byte, or from a 4-bit single-byte opcode, which works on the accumulator alone.

An input selects which opcode group is live. Instruction fetch, memory bus timing and the program counter sit outside this block. A sequencer presents the decoded opcode and the fetched operand, pulses the strobe, and reads the accumulator and flags back one cycle later. A one-cycle flag-update pulse follows every executed operation that wrote at least one flag, so branch logic can tell when the flags are fresh.

Subtraction reuses the adder. It inverts the operand and the carry input, so C behaves as an inverted borrow. Both add and subtract take C in, which lets multi-byte arithmetic chain through the carry.

Top module: `acc_alu_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, all four flags and the flag-update pulse, and it takes priority over a simultaneous execute strobe.
- R2: While exec is low the accumulator and flags hold their values. flag_upd is high for exactly the one cycle after an executed operation that writes at least one flag, and it is low at all other times.
- R3: Memory opcode 3'b000 (load) copies the operand into the accumulator. It sets Z to 1 if the result is zero and to 0 otherwise, sets N to result bit 7, and leaves C and V unchanged.
- R4: Memory opcode 3'b001 (AND) writes the bitwise AND of the accumulator and the operand. It updates Z and N from the result, and C and V are kept.
- R5: Memory opcode 3'b010 (add) writes acc + operand + C. C takes the carry out of bit 7. V is 1 exactly when both addends share a sign and the result sign differs from it. Z and N follow the result.
- R6: Memory opcode 3'b011 (subtract) writes acc + ~operand + ~C. C takes the carry out of bit 7. V follows the add rule applied to the inverted operand. Z and N follow the result.
- R7: Memory opcodes with bit 2 set (3'b1xx) change neither the accumulator nor any flag, and they raise no flag_upd.
- R8: Single opcode 4'b0001 clears the accumulator, leaves all four flags unchanged and raises no flag_upd.
- R9: Single opcode 4'b0010 inverts every accumulator bit and updates Z and N. C and V are kept.
- R10: Single opcode 4'b0100 inverts C and changes nothing else.
- R11: Single opcode 4'b1000 shifts the accumulator left by one and fills bit 0 with 0. C takes the old bit 7, V is new bit 7 XOR new C, and Z and N follow the result.
- R12: Single opcode 4'b1001 shifts the accumulator right by one, copies bit 7 into itself and drops bit 0. It updates Z and N, and C and V are kept.
- R13: Any other single opcode changes neither the accumulator nor any flag and raises no flag_upd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Execute strobe, one operation per high cycle |
| single_sel | input | 1 | 1 selects one_op, 0 selects mem_op |
| mem_op | input | 3 | Memory-operand opcode |
| one_op | input | 4 | Single-byte opcode |
| operand | input | W (8) | Memory operand byte |
| acc | output | W (8) | Accumulator |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_upd | output | 1 | One-cycle pulse after a flag-writing operation |

## Verification
The bench builds the block at its default width of 8. At that width the hand-derived vectors can use the exact boundary bytes 0x7F, 0x80, 0x00 and 0xFF. These bring signed overflow in both directions within reach, as well as carry out to zero, borrow through the inverted carry, and the two shift-left overflow cases. The vectors are chained so that each operation starts from flag values set by the one before. This shows which flags each operation keeps and which it overwrites, including a stale Z being cleared.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    localparam logic [2:0] MOP_LOAD = 3'b000;
    localparam logic [2:0] MOP_AND  = 3'b001;
    localparam logic [2:0] MOP_ADD  = 3'b010;
    localparam logic [2:0] MOP_SUB  = 3'b011;

    localparam logic [3:0] SOP_CLR  = 4'b0001;
    localparam logic [3:0] SOP_CMA  = 4'b0010;
    localparam logic [3:0] SOP_CMC  = 4'b0100;
    localparam logic [3:0] SOP_SHL  = 4'b1000;
    localparam logic [3:0] SOP_SHR  = 4'b1001;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_LOAD,
        OP_AND,
        OP_ADD,
        OP_SUB,
        OP_CLR,
        OP_CMA,
        OP_CMC,
        OP_SHL,
        OP_SHR
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic c;
        logic z;
        logic n;
    } flags_t;

    localparam int NFLAGS = $bits(flags_t);

    // Bitwise select: mask bit 1 takes the fresh value, 0 keeps the old one.
    function automatic flags_t merge_flags(flags_t old_f, flags_t new_f, flags_t mask);
        logic [NFLAGS-1:0] o, f, m;
        o = old_f;
        f = new_f;
        m = mask;
        return flags_t'((m & f) | (~m & o));
    endfunction

endpackage

// File: rtl/acc_op_decode.sv
`timescale 1ns/1ps
module acc_op_decode
    import acc_alu_pkg::*;
(
    input  logic       single_sel,
    input  logic [2:0] mem_op,
    input  logic [3:0] one_op,
    output alu_op_e    op
);

    always_comb begin
        op = OP_NONE;
        if (single_sel) begin
            case (one_op)
                SOP_CLR: op = OP_CLR;
                SOP_CMA: op = OP_CMA;
                SOP_CMC: op = OP_CMC;
                SOP_SHL: op = OP_SHL;
                SOP_SHR: op = OP_SHR;
                default: op = OP_NONE;
            endcase
        end else begin
            case (mem_op)
                MOP_LOAD: op = OP_LOAD;
                MOP_AND:  op = OP_AND;
                MOP_ADD:  op = OP_ADD;
                MOP_SUB:  op = OP_SUB;
                default:  op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/acc_adder.sv
`timescale 1ns/1ps
module acc_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   total;

    // Subtraction shares the adder: operand and carry-in are both inverted.
    assign b_eff = sub ? ~b : b;
    assign c_eff = sub ? ~cin : cin;
    assign total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    assign sum   = total[W-1:0];
    assign cout  = total[W];
    assign ovf   = (a[W-1] == b_eff[W-1]) && (total[W-1] != a[W-1]);

endmodule

// File: rtl/acc_next_state.sv
`timescale 1ns/1ps
module acc_next_state
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] acc_cur,
    input  logic [W-1:0] operand,
    input  flags_t       flags_cur,
    input  logic [W-1:0] add_sum,
    input  logic         add_cout,
    input  logic         add_ovf,
    output logic [W-1:0] acc_nxt,
    output flags_t       flags_nxt,
    output logic         flag_wr
);

    logic [W-1:0] res;
    flags_t       fresh;
    flags_t       mask;

    always_comb begin
        res   = acc_cur;
        fresh = flags_cur;
        mask  = '0;
        case (op)
            OP_LOAD: begin
                res    = operand;
                mask.z = 1'b1;
                mask.n = 1'b1;
            end
            OP_AND: begin
                res    = acc_cur & operand;
                mask.z = 1'b1;
                mask.n = 1'b1;
            end
            OP_ADD, OP_SUB: begin
                res     = add_sum;
                fresh.c = add_cout;
                fresh.v = add_ovf;
                mask    = '1;
            end
            OP_CLR: begin
                res = '0;
            end
            OP_CMA: begin
                res    = ~acc_cur;
                mask.z = 1'b1;
                mask.n = 1'b1;
            end
            OP_CMC: begin
                fresh.c = ~flags_cur.c;
                mask.c  = 1'b1;
            end
            OP_SHL: begin
                res     = {acc_cur[W-2:0], 1'b0};
                fresh.c = acc_cur[W-1];
                fresh.v = acc_cur[W-2] ^ acc_cur[W-1];
                mask    = '1;
            end
            OP_SHR: begin
                res    = {acc_cur[W-1], acc_cur[W-1:1]};
                mask.z = 1'b1;
                mask.n = 1'b1;
            end
            default: begin
                res = acc_cur;
            end
        endcase
        // Z is written both ways so a stale 1 never survives a write.
        fresh.z = (res == '0);
        fresh.n = res[W-1];
    end

    assign acc_nxt   = res;
    assign flags_nxt = merge_flags(flags_cur, fresh, mask);
    assign flag_wr   = |mask;

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec,
    input  logic         single_sel,
    input  logic [2:0]   mem_op,
    input  logic [3:0]   one_op,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc,
    output logic         flag_v,
    output logic         flag_c,
    output logic         flag_z,
    output logic         flag_n,
    output logic         flag_upd
);

    alu_op_e      op;
    logic [W-1:0] acc_q;
    flags_t       flags_q;
    logic         upd_q;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] acc_nxt;
    flags_t       flags_nxt;
    logic         flag_wr;

    acc_op_decode u_dec (
        .single_sel (single_sel),
        .mem_op     (mem_op),
        .one_op     (one_op),
        .op         (op)
    );

    acc_adder #(.W(W)) u_add (
        .a    (acc_q),
        .b    (operand),
        .cin  (flags_q.c),
        .sub  (op == OP_SUB),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    acc_next_state #(.W(W)) u_nxt (
        .op        (op),
        .acc_cur   (acc_q),
        .operand   (operand),
        .flags_cur (flags_q),
        .add_sum   (add_sum),
        .add_cout  (add_cout),
        .add_ovf   (add_ovf),
        .acc_nxt   (acc_nxt),
        .flags_nxt (flags_nxt),
        .flag_wr   (flag_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            flags_q <= '0;
            upd_q   <= 1'b0;
        end else begin
            upd_q <= exec && flag_wr;
            if (exec) begin
                acc_q   <= acc_nxt;
                flags_q <= flags_nxt;
            end
        end
    end

    assign acc      = acc_q;
    assign flag_v   = flags_q.v;
    assign flag_c   = flags_q.c;
    assign flag_z   = flags_q.z;
    assign flag_n   = flags_q.n;
    assign flag_upd = upd_q;

endmodule

// File: rtl/acc_alu_checker.sv
`timescale 1ns/1ps
module acc_alu_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         exec,
    input logic         single_sel,
    input logic [2:0]   mem_op,
    input logic [3:0]   one_op,
    input logic [W-1:0] operand,
    input logic [W-1:0] acc,
    input logic         flag_v,
    input logic         flag_c,
    input logic         flag_z,
    input logic         flag_n,
    input logic         flag_upd
);

    logic [3:0] fl;
    assign fl = {flag_v, flag_c, flag_z, flag_n};

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0 && fl == 4'b0000 && !flag_upd));

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !exec |=> ($stable(acc) && $stable(fl) && !flag_upd));

    // R2
    a_r2_upd_needs_exec: assert property (@(posedge clk) disable iff (rst)
        flag_upd |-> $past(exec));

    // R3
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (exec && !single_sel && mem_op == 3'b000) |=>
        (acc == $past(operand) && flag_z == (acc == '0) && flag_n == acc[W-1]
         && flag_c == $past(flag_c) && flag_v == $past(flag_v)));

    // R7
    a_r7_high_codes_ignored: assert property (@(posedge clk) disable iff (rst)
        (exec && !single_sel && mem_op[2]) |=>
        ($stable(acc) && $stable(fl) && !flag_upd));

    // R8
    a_r8_clear_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (exec && single_sel && one_op == 4'b0001) |=>
        (acc == '0 && $stable(fl) && !flag_upd));

    // R10
    a_r10_cmc_only_carry: assert property (@(posedge clk) disable iff (rst)
        (exec && single_sel && one_op == 4'b0100) |=>
        (flag_c != $past(flag_c) && $stable(acc) && $stable(flag_v)
         && $stable(flag_z) && $stable(flag_n)));

    // R12
    a_r12_shr_sign_kept: assert property (@(posedge clk) disable iff (rst)
        (exec && single_sel && one_op == 4'b1001) |=>
        (acc[W-1] == $past(acc[W-1]) && acc[W-2:0] == $past(acc[W-1:1])
         && $stable(flag_c) && $stable(flag_v)));

endmodule

bind acc_alu_core acc_alu_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .exec       (exec),
    .single_sel (single_sel),
    .mem_op     (mem_op),
    .one_op     (one_op),
    .operand    (operand),
    .acc        (acc),
    .flag_v     (flag_v),
    .flag_c     (flag_c),
    .flag_z     (flag_z),
    .flag_n     (flag_n),
    .flag_upd   (flag_upd)
);

// File: tb/test_acc_alu_core.sv
`timescale 1ns/1ps
module test_acc_alu_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec = 1'b0;
    logic       single_sel = 1'b0;
    logic [2:0] mem_op = 3'b000;
    logic [3:0] one_op = 4'b0000;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc;
    logic       flag_v, flag_c, flag_z, flag_n, flag_upd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu_core #(.W(8)) i_acc_alu_core (
        .clk        (clk),
        .rst        (rst),
        .exec       (exec),
        .single_sel (single_sel),
        .mem_op     (mem_op),
        .one_op     (one_op),
        .operand    (operand),
        .acc        (acc),
        .flag_v     (flag_v),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .flag_n     (flag_n),
        .flag_upd   (flag_upd)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       single;
        logic [3:0] code;
        logic [7:0] opnd;
        logic [7:0] e_acc;
        logic [3:0] e_vczn;
        logic       e_upd;
    } vec_t;

    localparam int NVEC = 22;
    // Flags are written V,C,Z,N. Vectors chain: each starts from the previous result.
    localparam vec_t VEC [NVEC] = '{
        '{4'd3,  1'b0, 4'h0, 8'h7F, 8'h7F, 4'b0000, 1'b1}, // R3 load
        '{4'd5,  1'b0, 4'h2, 8'h01, 8'h80, 4'b1001, 1'b1}, // R5 add, positive overflow
        '{4'd5,  1'b0, 4'h2, 8'h80, 8'h00, 4'b1110, 1'b1}, // R5 add, carry out and negative overflow
        '{4'd5,  1'b0, 4'h2, 8'h05, 8'h06, 4'b0000, 1'b1}, // R5 add with carry in
        '{4'd6,  1'b0, 4'h3, 8'h06, 8'h00, 4'b0110, 1'b1}, // R6 subtract equal, no borrow
        '{4'd6,  1'b0, 4'h3, 8'h01, 8'hFE, 4'b0001, 1'b1}, // R6 subtract with borrow
        '{4'd4,  1'b0, 4'h1, 8'h0F, 8'h0E, 4'b0000, 1'b1}, // R4 AND
        '{4'd10, 1'b1, 4'h4, 8'h00, 8'h0E, 4'b0100, 1'b1}, // R10 complement carry
        '{4'd4,  1'b0, 4'h1, 8'h81, 8'h00, 4'b0110, 1'b1}, // R4 AND to zero, C kept
        '{4'd9,  1'b1, 4'h2, 8'h00, 8'hFF, 4'b0101, 1'b1}, // R9 complement acc
        '{4'd12, 1'b1, 4'h9, 8'h00, 8'hFF, 4'b0101, 1'b1}, // R12 shift right all ones
        '{4'd3,  1'b0, 4'h0, 8'h40, 8'h40, 4'b0100, 1'b1}, // R3 load keeps C
        '{4'd11, 1'b1, 4'h8, 8'h00, 8'h80, 4'b1001, 1'b1}, // R11 shift left into sign
        '{4'd11, 1'b1, 4'h8, 8'h00, 8'h00, 4'b1110, 1'b1}, // R11 shift left out of sign
        '{4'd3,  1'b0, 4'h0, 8'h81, 8'h81, 4'b1101, 1'b1}, // R3 load keeps V and C
        '{4'd12, 1'b1, 4'h9, 8'h00, 8'hC0, 4'b1101, 1'b1}, // R12 sign replicated
        '{4'd8,  1'b1, 4'h1, 8'h00, 8'h00, 4'b1101, 1'b0}, // R8 clear keeps flags
        '{4'd7,  1'b0, 4'h4, 8'h55, 8'h00, 4'b1101, 1'b0}, // R7 code 100 ignored
        '{4'd13, 1'b1, 4'h3, 8'h00, 8'h00, 4'b1101, 1'b0}, // R13 code 0011 ignored
        '{4'd6,  1'b0, 4'h3, 8'h00, 8'hFF, 4'b0001, 1'b1}, // R6 subtract zero with carry set
        '{4'd3,  1'b0, 4'h0, 8'h80, 8'h80, 4'b0001, 1'b1}, // R3 load negative
        '{4'd6,  1'b0, 4'h3, 8'h01, 8'h7F, 4'b1100, 1'b1}  // R6 subtract overflow
    };

    task automatic check(input string req, input logic [7:0] e_acc,
                         input logic [3:0] e_fl, input logic e_upd);
        logic [3:0] fl;
        fl = {flag_v, flag_c, flag_z, flag_n};
        checks++;
        if (acc !== e_acc || fl !== e_fl || flag_upd !== e_upd) begin
            errors++;
            $display("FAIL %s: acc=%h vczn=%b upd=%b expected acc=%h vczn=%b upd=%b",
                     req, acc, fl, flag_upd, e_acc, e_fl, e_upd);
        end
    endtask

    task automatic apply(input logic sgl, input logic [3:0] code, input logic [7:0] opnd);
        @(negedge clk);
        single_sel = sgl;
        mem_op     = code[2:0];
        one_op     = code;
        operand    = opnd;
        exec       = 1'b1;
        @(negedge clk);
        exec       = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h00, 4'b0000, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].single, VEC[i].code, VEC[i].opnd);
            check($sformatf("R%0d vector %0d", VEC[i].req, i),
                  VEC[i].e_acc, VEC[i].e_vczn, VEC[i].e_upd);
        end

        // R2: no strobe, inputs wiggle, state holds and no pulse
        single_sel = 1'b0;
        mem_op     = 3'b000;
        operand    = 8'h33;
        repeat (3) @(negedge clk);
        check("R2 idle hold", 8'h7F, 4'b1100, 1'b0);

        // R3: load zero sets Z, keeps V and C
        apply(1'b0, 4'h0, 8'h00);
        check("R3 load zero", 8'h00, 4'b1110, 1'b1);
        // R2: pulse lasts one cycle only
        @(negedge clk);
        check("R2 pulse width", 8'h00, 4'b1110, 1'b0);

        // R1: reset wins over a simultaneous strobe
        apply(1'b0, 4'h0, 8'h5A);
        check("R3 load before reset", 8'h5A, 4'b1100, 1'b1);
        @(negedge clk);
        rst        = 1'b1;
        exec       = 1'b1;
        single_sel = 1'b0;
        mem_op     = 3'b000;
        operand    = 8'h33;
        @(negedge clk);
        exec = 1'b0;
        check("R1 reset priority", 8'h00, 4'b0000, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule